// File: doc/BRIEF.md
# Periodic Interval Timer with Restart

This block produces a regular interrupt for a small processor. Software writes an 8-bit interval over a simple byte-wide write port. The block counts that many strobes of a shared microsecond tick input. When the count runs out, it raises a one-clock interrupt strobe and starts the same period again. The stored interval can always be read back on a parallel output.

A new interval takes effect at the moment it is written. The counter is reloaded straight away, and the old period is dropped without firing. A write never causes an interrupt of its own. An interval of zero parks the timer: it counts nothing and signals nothing. The tick input is only observed. Tick generation stays with whatever drives it, so other logic sharing that strobe runs on whatever the timer holds.

The reset input is asynchronous and active low. Inside the block its release is synchronised to the clock, so the block is held in reset for two clock edges after the pin goes high.

Top module: `pit_top`

## Requirements
- R1: While in reset, and after reset until the first write, `rd_data_o` reads 0 and `irq_o` is 0.
- R2: A write with `wr_en_i` high stores `wr_data_i`. The value is visible on `rd_data_o` one clock later and holds until the next write.
- R3: After interval N (1 to 255) is written, `irq_o` is high for exactly one clock after the edge that samples the N-th tick. It then repeats after every further N ticks. The spacing of the ticks in clock cycles does not change this.
- R4: A write in the middle of a count discards the remaining count. The next interrupt follows exactly N ticks of the new interval, and no interrupt comes from the old count.
- R5: `irq_o` is 0 in the cycle after any write, even if the old count would have expired on that edge.
- R6: A tick sampled on the same edge as a write is ignored. Counting of the new interval starts with the next tick.
- R7: With the stored interval at 0, `irq_o` stays 0 however many ticks arrive.
- R8: `irq_o` is never high unless a tick was sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Shared microsecond strobe, one clock wide per tick |
| wr_en_i | input | 1 | Interval write enable |
| wr_data_i | input | 8 | Interval to store (0 disables the timer) |
| rd_data_o | output | 8 | Read-back of the stored interval |
| irq_o | output | 1 | One-clock interrupt strobe on expiry |

## Verification
The bench sweeps intervals 1 through 9 and 255, with ticks arriving back to back and also spread three cycles apart. It compares every tick against a modulo prediction. An off-by-one in the reload would stretch or shrink every period, and the interval-1 case would expose a design that cannot fire on consecutive ticks. Rewrites are aimed at the worst moment: at the tick where the old count sits at 1, and together with a tick on the write edge. A design that let the old count finish would emit a spurious strobe, and one that honoured the coincident tick would fire one tick early. Zero is tested for silence over a long run of ticks, and then for a clean restart when a nonzero interval follows.

// File: rtl/pit_pkg.sv
package pit_pkg;
  parameter int unsigned PIT_W = 8;
  parameter int unsigned PIT_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOAD   = 2'd1,
    ACT_DEC    = 2'd2,
    ACT_RELOAD = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/pit_rst_sync.sv
module pit_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/pit_ival_reg.sv
module pit_ival_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] ival_o
);
  logic [W-1:0] ival_q;
  logic [W-1:0] ival_d;
  logic         ival_en;

  always_comb begin
    ival_en = wr_en_i;
    ival_d  = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ival_q <= '0;
    else if (ival_en) ival_q <= ival_d;
  end

  assign ival_o = ival_q;

  // R2
  ival_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> (ival_o == $past(ival_o)));
endmodule

// File: rtl/pit_downcnt.sv
module pit_downcnt
  import pit_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] ival_i,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  cnt_act_e     act;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    act = ACT_HOLD;
    if (load_i)
      act = ACT_LOAD;
    else if (tick_i && (ival_i != '0))
      act = (cnt_q == ONE) ? ACT_RELOAD : ACT_DEC;
  end

  always_comb begin
    cnt_d = cnt_q;
    unique case (act)
      ACT_LOAD:   cnt_d = load_val_i;
      ACT_RELOAD: cnt_d = ival_i;
      ACT_DEC:    cnt_d = cnt_q - ONE;
      default:    cnt_d = cnt_q;
    endcase
    cnt_en = (act != ACT_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = (act == ACT_RELOAD);

  // R4
  load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ival_i);

  // R7
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ival_i == '0) |-> (cnt_q == '0));
endmodule

// File: rtl/pit_top.sv
module pit_top
  import pit_pkg::*;
#(
  parameter int unsigned W           = PIT_W,
  parameter int unsigned SYNC_STAGES = PIT_SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] rd_data_o,
  output logic         irq_o
);
  logic         rst_n_int;
  logic [W-1:0] ival;
  logic         expire;
  logic         irq_q;
  logic         irq_d;

  pit_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  pit_ival_reg #(.W(W)) u_ival (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ival_o    (ival)
  );

  pit_downcnt #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick_i     (tick_i),
    .load_i     (wr_en_i),
    .load_val_i (wr_data_i),
    .ival_i     (ival),
    .expire_o   (expire)
  );

  always_comb irq_d = expire;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  assign irq_o     = irq_q;
  assign rd_data_o = ival;

  // R5
  no_wr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    wr_en_i |=> !irq_o);

  // R8
  irq_tick_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq_o |-> $past(tick_i));

  // R7
  zero_irq_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((rd_data_o == '0) && !wr_en_i) |=> !irq_o);
endmodule

// File: tb/pit_top_tb.sv
`timescale 1ns/1ps
module pit_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i;
  logic       wr_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  pit_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample 1 ns after the following posedge
  task automatic step(input bit tk, input bit wr, input logic [7:0] d);
    @(negedge clk);
    tick_i    = tk;
    wr_en_i   = wr;
    wr_data_i = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    tick_i  = 1'b0;
    wr_en_i = 1'b0;
  endtask

  task automatic step_irq(input bit tk, input bit wr, input logic [7:0] d,
                          input bit exp_irq, input string req);
    @(negedge clk);
    tick_i    = tk;
    wr_en_i   = wr;
    wr_data_i = d;
    @(posedge clk);
    #1;
    check(irq_o == exp_irq, req, int'(irq_o), int'(exp_irq));
  endtask

  task automatic idle_to_negedge();
    @(negedge clk);
    tick_i  = 1'b0;
    wr_en_i = 1'b0;
  endtask

  task automatic run_period(input int n, input int gap);
    step_irq(1'b0, 1'b1, 8'(n), 1'b0, "R5");
    check(rd_data_o == 8'(n), "R2", int'(rd_data_o), n);
    for (int k = 1; k <= 3 * n; k++) begin
      step_irq(1'b1, 1'b0, 8'h00, (k % n) == 0, "R3");
      for (int g = 0; g < gap; g++)
        step_irq(1'b0, 1'b0, 8'h00, 1'b0, "R8");
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; wr_data_i = 8'h00;
    #1;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check(rd_data_o == 8'h00, "R1", int'(rd_data_o), 0);
    check(irq_o == 1'b0, "R1", int'(irq_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 8'h00);
    // R1 after reset, ticks with no write
    for (int k = 0; k < 5; k++) step_irq(1'b1, 1'b0, 8'h00, 1'b0, "R1");
    check(rd_data_o == 8'h00, "R1", int'(rd_data_o), 0);

    // R3 sweep of periods, back-to-back and spaced ticks
    for (int n = 1; n <= 9; n++) begin
      run_period(n, 0);
      run_period(n, 2);
    end
    run_period(255, 0);

    // R4 mid-count rewrite: 10 loaded, 7 ticks, then rewrite to 4
    step_irq(1'b0, 1'b1, 8'd10, 1'b0, "R5");
    for (int k = 0; k < 7; k++) step_irq(1'b1, 1'b0, 8'h00, 1'b0, "R4");
    step_irq(1'b0, 1'b1, 8'd4, 1'b0, "R5");
    for (int k = 1; k <= 8; k++) step_irq(1'b1, 1'b0, 8'h00, (k % 4) == 0, "R4");

    // R5 rewrite on the edge where the old count would expire (tick together)
    step_irq(1'b0, 1'b1, 8'd5, 1'b0, "R5");
    for (int k = 0; k < 4; k++) step_irq(1'b1, 1'b0, 8'h00, 1'b0, "R4");
    step_irq(1'b1, 1'b1, 8'd5, 1'b0, "R5");
    // R6 the coincident tick did not count: irq only on 5th following tick
    for (int k = 1; k <= 5; k++) step_irq(1'b1, 1'b0, 8'h00, k == 5, "R6");

    // R6 again with interval 1: tick on write ignored, next tick fires
    step_irq(1'b1, 1'b1, 8'd1, 1'b0, "R6");
    step_irq(1'b0, 1'b0, 8'h00, 1'b0, "R6");
    step_irq(1'b1, 1'b0, 8'h00, 1'b1, "R6");

    // R7 zero interval: silent over many ticks
    step_irq(1'b1, 1'b1, 8'd0, 1'b0, "R7");
    check(rd_data_o == 8'h00, "R2", int'(rd_data_o), 0);
    for (int k = 0; k < 300; k++) step_irq(1'b1, 1'b0, 8'h00, 1'b0, "R7");
    // restart from zero
    step_irq(1'b0, 1'b1, 8'd3, 1'b0, "R5");
    for (int k = 1; k <= 6; k++) step_irq(1'b1, 1'b0, 8'h00, (k % 3) == 0, "R7");

    // R2 hold without writes
    check(rd_data_o == 8'd3, "R2", int'(rd_data_o), 3);
    idle_to_negedge();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule